// File: doc/BRIEF.md
# Redundant Word Voter with Spare Substitution

This block takes three redundant copies of a data word, produced by replicated modules, plus a fourth spare copy. It produces one trusted result word. All four words are compared with each other as whole words. If the three primary copies agree, that value passes through. If exactly one primary copy disagrees, the block outputs the value the other two share and marks which copy it overruled.

If all three primaries disagree, a plain majority vote has no answer. This block then uses the spare copy: any primary that matches the spare is taken as the result, and the two primaries that do not match are marked. If no value can be trusted, the block raises an unrecoverable-error flag.

A parameter sets the congruency level: how many of the four inputs must hold the chosen value before it is accepted. Results are registered with one cycle of latency and carry a valid strobe.

Top module: `vsp_voter`

## Requirements
- R1: When X1, X2 and X3 are all equal, `vote_q` equals that value, `err_q` is 000 and `corr_q`, `spare_q` and `fatal_q` are 0, whatever X4 holds (provided the congruency level is met).
- R2: When exactly one primary differs from the other two, `vote_q` is the shared value, `corr_q` is 1, and `err_q` is one-hot with bit 0 for X1, bit 1 for X2 and bit 2 for X3 marking the outlier.
- R3: When all three primaries differ and one of them equals X4, `vote_q` is that primary, `spare_q` is 1, and `err_q` has exactly the two other primaries' bits set.
- R4: When all three primaries differ and none equals X4, `fatal_q` is 1, `vote_q` is 0 and `err_q` is 111.
- R5: A candidate value is accepted only if at least AGREE_MIN of the four inputs equal it; otherwise the result is the R4 fatal result. With AGREE_MIN = 3, a single-error case is corrected only when X4 matches the majority, and a spare case always becomes fatal.
- R6: A word set sampled with `in_valid` high appears on the outputs, with `valid_q` high, on the next clock edge.
- R7: When `in_valid` is low, `valid_q` is 0 on the next edge and `vote_q`, `err_q` and the flags keep their values.
- R8: During and right after reset, `valid_q`, `vote_q`, `err_q`, `corr_q`, `spare_q` and `fatal_q` are all 0.
- R9: At most one of `corr_q`, `spare_q` and `fatal_q` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The four input words are valid this cycle |
| x1 | input | WIDTH | Primary copy 1 |
| x2 | input | WIDTH | Primary copy 2 |
| x3 | input | WIDTH | Primary copy 3 |
| x4 | input | WIDTH | Spare copy |
| valid_q | output | 1 | A result is present this cycle |
| vote_q | output | WIDTH | Voted word (0 when unrecoverable) |
| err_q | output | 3 | Primaries that disagree with the result |
| corr_q | output | 1 | A single primary was overruled |
| spare_q | output | 1 | The spare decided the vote |
| fatal_q | output | 1 | No trusted value could be produced |

## Verification
The assertions assume that the four words carry no unknown bits whenever `in_valid` is high. Otherwise the word compares would not settle into one of the four cases, and the flag-pattern checks would be meaningless. The stimulus always drives fully defined words, and it keeps them defined while `in_valid` is low, so the hold behaviour is checked against known values. Each scenario task builds its word sets from distinct fixed constants, so the intended equalities hold exactly and no accidental match can occur.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

  localparam int N_IN = 4;

  typedef enum logic [1:0] {
    VC_CLEAN  = 2'd0,
    VC_SINGLE = 2'd1,
    VC_SPARE  = 2'd2,
    VC_FAIL   = 2'd3
  } vote_case_e;

  // population count of an agreement mask
  function automatic logic [2:0] agree_count(input logic [N_IN-1:0] m);
    logic [2:0] c;
    c = '0;
    for (int i = 0; i < N_IN; i++) c = c + {2'b00, m[i]};
    return c;
  endfunction

endpackage

// File: rtl/vsp_pair_eq.sv
module vsp_pair_eq #(
  parameter int WIDTH = 16,
  parameter int N_IN  = 4
) (
  input  logic [N_IN-1:0][WIDTH-1:0] words,
  output logic [N_IN-1:0][N_IN-1:0]  eq
);

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_row
    for (genvar gj = 0; gj < N_IN; gj++) begin : g_col
      assign eq[gi][gj] = (words[gi] == words[gj]);
    end
  end

endmodule

// File: rtl/vsp_decide.sv
module vsp_decide
  import vsp_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int AGREE_MIN = 2
) (
  input  logic [N_IN-1:0][WIDTH-1:0] words,
  input  logic [N_IN-1:0][N_IN-1:0]  eq,
  output logic [WIDTH-1:0]           vote,
  output logic [2:0]                 err,
  output vote_case_e                 vcase
);

  localparam logic [2:0] AMIN = 3'(AGREE_MIN);

  logic [1:0]      src;
  logic [N_IN-1:0] agree_mask;
  logic [2:0]      agree_cnt;
  vote_case_e      raw_case;

  // pick the source primary and the raw case from pairwise equality
  always_comb begin
    src      = 2'd0;
    raw_case = VC_CLEAN;
    if (eq[0][1] && eq[0][2]) begin
      src = 2'd0; raw_case = VC_CLEAN;
    end else if (eq[0][1] || eq[0][2]) begin
      src = 2'd0; raw_case = VC_SINGLE;
    end else if (eq[1][2]) begin
      src = 2'd1; raw_case = VC_SINGLE;
    end else if (eq[0][3]) begin
      src = 2'd0; raw_case = VC_SPARE;
    end else if (eq[1][3]) begin
      src = 2'd1; raw_case = VC_SPARE;
    end else if (eq[2][3]) begin
      src = 2'd2; raw_case = VC_SPARE;
    end else begin
      raw_case = VC_FAIL;
    end
  end

  assign agree_mask = eq[src];
  assign agree_cnt  = agree_count(agree_mask);

  // congruency gate, then result formation
  always_comb begin
    vcase = raw_case;
    if (raw_case != VC_FAIL && agree_cnt < AMIN) vcase = VC_FAIL;
    if (vcase == VC_FAIL) begin
      vote = '0;
      err  = 3'b111;
    end else begin
      vote = words[src];
      err  = ~agree_mask[2:0];
    end
  end

endmodule

// File: rtl/vsp_voter.sv
module vsp_voter
  import vsp_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int AGREE_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] x1,
  input  logic [WIDTH-1:0] x2,
  input  logic [WIDTH-1:0] x3,
  input  logic [WIDTH-1:0] x4,
  output logic             valid_q,
  output logic [WIDTH-1:0] vote_q,
  output logic [2:0]       err_q,
  output logic             corr_q,
  output logic             spare_q,
  output logic             fatal_q
);

  logic [N_IN-1:0][WIDTH-1:0] words;
  logic [N_IN-1:0][N_IN-1:0]  eq;
  logic [WIDTH-1:0]           vote_d;
  logic [2:0]                 err_d;
  vote_case_e                 case_d;

  assign words = {x4, x3, x2, x1};

  vsp_pair_eq #(.WIDTH(WIDTH), .N_IN(N_IN)) u_eq (
    .words (words),
    .eq    (eq)
  );

  vsp_decide #(.WIDTH(WIDTH), .AGREE_MIN(AGREE_MIN)) u_decide (
    .words (words),
    .eq    (eq),
    .vote  (vote_d),
    .err   (err_d),
    .vcase (case_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vote_q  <= '0;
      err_q   <= '0;
      corr_q  <= 1'b0;
      spare_q <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        vote_q  <= vote_d;
        err_q   <= err_d;
        corr_q  <= (case_d == VC_SINGLE);
        spare_q <= (case_d == VC_SPARE);
        fatal_q <= (case_d == VC_FAIL);
      end
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({corr_q, spare_q, fatal_q})); // R9
  AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && corr_q) |-> ($countones(err_q) == 1)); // R2
  AST_SPARE_TWO_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && spare_q) |-> ($countones(err_q) == 2)); // R3
  AST_FATAL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && fatal_q) |-> (err_q == 3'b111 && vote_q == '0)); // R4
  AST_CLEAN_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !corr_q && !spare_q && !fatal_q) |-> (err_q == 3'b000)); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> valid_q); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!valid_q && $stable(vote_q) && $stable(err_q))); // R7

endmodule

// File: tb/test_vsp_voter.sv
module test_vsp_voter;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] x1 = '0, x2 = '0, x3 = '0, x4 = '0;

  logic         valid_a, corr_a, spare_a, fatal_a;
  logic [W-1:0] vote_a;
  logic [2:0]   err_a;
  logic         valid_b, corr_b, spare_b, fatal_b;
  logic [W-1:0] vote_b;
  logic [2:0]   err_b;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vsp_voter #(.WIDTH(W), .AGREE_MIN(2)) i_vsp_voter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x1(x1), .x2(x2), .x3(x3), .x4(x4),
    .valid_q(valid_a), .vote_q(vote_a), .err_q(err_a),
    .corr_q(corr_a), .spare_q(spare_a), .fatal_q(fatal_a)
  );

  vsp_voter #(.WIDTH(W), .AGREE_MIN(3)) i_vsp_voter_strict (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x1(x1), .x2(x2), .x3(x3), .x4(x4),
    .valid_q(valid_b), .vote_q(vote_b), .err_q(err_b),
    .corr_q(corr_b), .spare_q(spare_b), .fatal_q(fatal_b)
  );

  // expected result: pack {fatal, spare, corr, err[2:0], vote}
  function automatic logic [W+5:0] model(input logic [W-1:0] a, b, c, s, input int amin);
    logic [W-1:0] p [3];
    logic [W-1:0] v;
    logic [2:0]   e;
    logic         co, sp, fa, got;
    int           prim, tot;
    p[0] = a; p[1] = b; p[2] = c;
    got = 1'b0; co = 1'b0; sp = 1'b0; fa = 1'b0; v = '0;
    for (int k = 0; k < 3; k++) begin
      prim = 0;
      for (int m = 0; m < 3; m++) if (p[m] == p[k]) prim++;
      if (!got && prim >= 2) begin got = 1'b1; v = p[k]; co = (prim == 2); end
    end
    if (!got) begin
      for (int k = 0; k < 3; k++)
        if (!got && p[k] == s) begin got = 1'b1; v = p[k]; sp = 1'b1; end
    end
    if (got) begin
      tot = (s == v) ? 1 : 0;
      for (int m = 0; m < 3; m++) if (p[m] == v) tot++;
      if (tot < amin) got = 1'b0;
    end
    if (!got) begin
      fa = 1'b1; co = 1'b0; sp = 1'b0; v = '0; e = 3'b111;
    end else begin
      for (int m = 0; m < 3; m++) e[m] = (p[m] != v);
    end
    return {fa, sp, co, e, v};
  endfunction

  task automatic check(input string req, input logic [W+5:0] act, input logic [W+5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one word set, then compare both instances after the edge
  task automatic vote_once(input string req, input logic [W-1:0] a, b, c, s);
    @(negedge clk);
    x1 = a; x2 = b; x3 = c; x4 = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R6 valid"}, {{(W+5){1'b0}}, valid_a & valid_b}, {{(W+5){1'b0}}, 1'b1});
    check({req, " amin2"}, {fatal_a, spare_a, corr_a, err_a, vote_a}, model(a, b, c, s, 2));
    check({req, " amin3 R5"}, {fatal_b, spare_b, corr_b, err_b, vote_b}, model(a, b, c, s, 3));
  endtask

  task automatic t_reset;
    check("R8 reset", {fatal_a, spare_a, corr_a, err_a, vote_a}, '0);
    check("R8 reset valid", {{(W+5){1'b0}}, valid_a | valid_b}, '0);
  endtask

  task automatic t_clean;
    vote_once("R1 clean spare-match", 16'h1234, 16'h1234, 16'h1234, 16'h1234);
    vote_once("R1 clean spare-off", 16'hA5A5, 16'hA5A5, 16'hA5A5, 16'h0F0F);
    check("R1 explicit", {fatal_a, spare_a, corr_a, err_a, vote_a},
          {3'b000, 3'b000, 16'hA5A5});
  endtask

  task automatic t_single;
    vote_once("R2 x1 bad", 16'h0001, 16'hBEEF, 16'hBEEF, 16'h7777);
    check("R2 x1 flags", {corr_a, err_a, vote_a}, {1'b1, 3'b001, 16'hBEEF});
    vote_once("R2 x2 bad", 16'hBEEF, 16'h0002, 16'hBEEF, 16'hBEEF);
    check("R2 x2 flags", {corr_a, err_a, vote_a}, {1'b1, 3'b010, 16'hBEEF});
    vote_once("R2 x3 bad", 16'hBEEF, 16'hBEEF, 16'h0003, 16'h7777);
    check("R2 x3 flags", {corr_a, err_a, vote_a}, {1'b1, 3'b100, 16'hBEEF});
  endtask

  task automatic t_spare;
    vote_once("R3 spare=x1", 16'h4444, 16'h5555, 16'h6666, 16'h4444);
    check("R3 x1 flags", {spare_a, err_a, vote_a}, {1'b1, 3'b110, 16'h4444});
    vote_once("R3 spare=x2", 16'h4444, 16'h5555, 16'h6666, 16'h5555);
    check("R3 x2 flags", {spare_a, err_a, vote_a}, {1'b1, 3'b101, 16'h5555});
    vote_once("R3 spare=x3", 16'h4444, 16'h5555, 16'h6666, 16'h6666);
    check("R3 x3 flags", {spare_a, err_a, vote_a}, {1'b1, 3'b011, 16'h6666});
    check("R5 strict spare fatal", {fatal_b, err_b, vote_b}, {1'b1, 3'b111, 16'h0000});
  endtask

  task automatic t_fatal;
    vote_once("R4 spare mismatch", 16'h1111, 16'h2222, 16'h3333, 16'h9999);
    check("R4 flags", {fatal_a, spare_a, corr_a, err_a, vote_a},
          {3'b100, 3'b111, 16'h0000});
  endtask

  task automatic t_congruency;
    vote_once("R5 single no spare", 16'hC0DE, 16'hC0DE, 16'h0BAD, 16'h1357);
    check("R5 strict fatal", {fatal_b, corr_b}, 2'b10);
    vote_once("R5 single with spare", 16'hC0DE, 16'hC0DE, 16'h0BAD, 16'hC0DE);
    check("R5 strict corrected", {fatal_b, corr_b, err_b, vote_b}, {2'b01, 3'b100, 16'hC0DE});
  endtask

  task automatic t_hold;
    vote_once("R7 setup", 16'h2468, 16'h2468, 16'h2468, 16'h2468);
    @(negedge clk);
    x1 = 16'hFFFF; x2 = 16'h0000; x3 = 16'h1111; x4 = 16'h2222;
    @(negedge clk);
    @(negedge clk);
    check("R7 hold", {valid_a, fatal_a, spare_a, corr_a, err_a, vote_a},
          {1'b0, 3'b000, 3'b000, 16'h2468});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_spare();
    t_fatal();
    t_congruency();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule